// File: doc/BRIEF.md
# Two-Law Serial Clock Divider

This block derives the serial clock of an SPI host from the bus clock. It gives the shifter a serial clock level and a pair of one-cycle strobes: one for each edge that leaves the idle level (leading) and one for each edge that returns to it (trailing). The shifter uses these strobes to sample and launch data. Computing the divider value and shifting the data are done elsewhere.

Two division laws are available, chosen by a law bit. The power-of-two law uses the low four bits of the divider field as an exponent N and divides by 2^(N+1). The linear law uses the full eight-bit field N and divides by 2·(N+1). The serial clock toggles only while the controller is enabled and a transfer is running. At any other time it rests at the level that the polarity input selects.

The divider field, the law bit and the polarity are copied into working registers. The copy is taken on every cycle in which the clock is not running, and also on a frame-done pulse. Changes made in the middle of a frame therefore cannot distort the clock that is being produced.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is held, and on the first cycle after its release, `sclk` is 0 and both strobes are 0.
- R2: With `law_sel`=0 and the clock running, `sclk` toggles every 2^N bus cycles, where N is `div_val[3:0]`. Bits `div_val[7:4]` have no effect in this law.
- R3: With `law_sel`=1 and the clock running, `sclk` toggles every N+1 bus cycles, where N is `div_val[7:0]`.
- R4: `lead_stb` is high for exactly the one cycle in which `sclk` moves away from the latched idle level. `trail_stb` is high for exactly the one cycle in which `sclk` moves back to that level.
- R5: When `enable` or `run` is low, one cycle later `sclk` equals the `cpol` value sampled on that edge, no strobe is asserted, and the divider count returns to zero.
- R6: While `enable` and `run` are both high, changes to `div_val`, `law_sel` and `cpol` are ignored. They take effect only after a cycle with `frame_done` high, or after a cycle in which the clock is not running. A `frame_done` cycle also restarts the count from zero without toggling.
- R7: After the clock starts running, or after a `frame_done` cycle, the first toggle appears exactly one half-period (2^N or N+1 cycles) later.
- R8: `lead_stb` and `trail_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low forces idle |
| run | input | 1 | Transfer in progress; clock runs only when high |
| frame_done | input | 1 | Frame boundary pulse; reloads settings and restarts the count |
| law_sel | input | 1 | 0 = power-of-two law, 1 = linear law |
| div_val | input | 8 | Divider field N |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe on an edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on an edge returning to idle |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- the idle level and the absence of strobes after a not-running cycle;
- the stability of the latched settings in the middle of a frame;
- each strobe coinciding with an actual change of `sclk`;
- the two strobes being mutually exclusive;
- the divider count staying below its limit.

The exact toggle spacing for each law and exponent, the delay before the first edge, and the moment at which a mid-frame change finally takes effect are shown only by the bench scenarios. In those scenarios a behavioural model tracks every output cycle by cycle.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;
endpackage

// File: rtl/sclk_half_limit.sv
// Converts the latched divider setting into a half-period length in bus cycles.
module sclk_half_limit
   import spi_div_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int EXP_W = 4,
   parameter int H_W   = 16
) (
   input  div_law_e          law,
   input  logic [DIV_W-1:0]  div,
   output logic [H_W-1:0]    half
);
   localparam int NPOW = 2 ** EXP_W;

   logic [NPOW-1:0] pow_vec;

   // one-hot decode of the exponent: bit i set when exponent equals i
   for (genvar i = 0; i < NPOW; i++) begin : g_pow
      assign pow_vec[i] = (div[EXP_W-1:0] == EXP_W'(i));
   end

   logic [H_W-1:0] lin_half;
   logic [H_W-1:0] pow_half;

   assign lin_half = {{(H_W-DIV_W){1'b0}}, div} + H_W'(1);
   assign pow_half = H_W'(pow_vec);
   assign half     = (law == LAW_LINEAR) ? lin_half : pow_half;
endmodule

// File: rtl/sclk_tick_counter.sv
// Counts bus cycles and issues a tick at the end of each half-period.
module sclk_tick_counter #(
   parameter int H_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic [H_W-1:0] limit,
   output logic           tick
);
   logic [H_W-1:0] cnt;
   logic           at_end;

   assign at_end = (cnt == limit - H_W'(1));
   assign tick   = !clear && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (at_end) cnt <= '0;
      else             cnt <= cnt + H_W'(1);
   end

   // R3 / R2: the count never reaches the half-period limit
   p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit);
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
   import spi_div_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             run,
   input  logic             frame_done,
   input  logic             law_sel,
   input  logic [DIV_W-1:0] div_val,
   input  logic             cpol,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);
   localparam int POW_W = 2 ** EXP_W;
   localparam int H_W   = (DIV_W + 1 > POW_W) ? DIV_W + 1 : POW_W;

   if (EXP_W < 1 || EXP_W > DIV_W) begin : g_bad_exp
      $error("EXP_W must lie between 1 and DIV_W");
   end

   logic             active;
   logic             load;
   logic [DIV_W-1:0] cur_div;
   div_law_e         cur_law;
   logic             cur_pol;
   logic [H_W-1:0]   half;
   logic             tick;

   assign active = enable && run;
   assign load   = !active || frame_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_div <= '0;
         cur_law <= LAW_POW2;
         cur_pol <= 1'b0;
      end else if (load) begin
         cur_div <= div_val;
         cur_law <= div_law_e'(law_sel);
         cur_pol <= cpol;
      end
   end

   sclk_half_limit #(.DIV_W(DIV_W), .EXP_W(EXP_W), .H_W(H_W)) u_limit (
      .law  (cur_law),
      .div  (cur_div),
      .half (half)
   );

   sclk_tick_counter #(.H_W(H_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .limit (half),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk      <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else begin
         lead_stb  <= tick && (sclk == cur_pol);
         trail_stb <= tick && (sclk != cur_pol);
         if (!active)   sclk <= cpol;
         else if (tick) sclk <= !sclk;
      end
   end

   // R5: a not-running cycle leaves the clock at the sampled idle level, quiet
   p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

   // R6: settings stay frozen in the middle of a frame
   p_hold_mid_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !frame_done) |=> $stable(cur_div) && $stable(cur_law) && $stable(cur_pol));

   // R4: every strobe marks a real change of the serial clock
   p_strobe_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

   // R4: a leading strobe leaves the idle level
   p_lead_leaves_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sclk != cur_pol));

   // R8: strobes are exclusive
   p_strobe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));
endmodule

// File: tb/sim_spi_sclk_divider.sv
`timescale 1ns/1ps
module sim_spi_sclk_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       run = 1'b0;
   logic       frame_done = 1'b0;
   logic       law_sel = 1'b0;
   logic [7:0] div_val = 8'd0;
   logic       cpol = 1'b0;
   logic       sclk, lead_stb, trail_stb;

   int checks = 0;
   int errors = 0;
   string req_tag = "R1";
   bit compare_on = 1'b0;
   bit done = 1'b0;

   // behavioural reference state
   int m_cnt = 0;
   bit m_sclk = 0, m_lead = 0, m_trail = 0;
   int m_div = 0;
   bit m_law = 0, m_pol = 0;

   always #2.5 clk = ~clk;

   spi_sclk_divider u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
      .frame_done(frame_done), .law_sel(law_sel), .div_val(div_val),
      .cpol(cpol), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_sclk = 0; m_lead = 0; m_trail = 0;
         m_div = 0; m_law = 0; m_pol = 0;
      end else begin
         bit act, clr, tk, nsclk;
         int lim, ncnt;
         act = enable && run;
         clr = !act || frame_done;
         lim = m_law ? (m_div + 1) : (1 << (m_div % 16));
         tk  = act && !frame_done && (m_cnt == lim - 1);
         m_lead  = tk && (m_sclk == m_pol);
         m_trail = tk && (m_sclk != m_pol);
         nsclk = !act ? cpol : (tk ? !m_sclk : m_sclk);
         ncnt  = clr ? 0 : ((m_cnt == lim - 1) ? 0 : m_cnt + 1);
         m_sclk = nsclk;
         m_cnt  = ncnt;
         if (clr) begin
            m_div = div_val; m_law = law_sel; m_pol = cpol;
         end
      end
   end

   task automatic check_bit(string what, bit act_v, bit exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req_tag, what, act_v, exp_v, $time);
      end
   endtask

   always @(negedge clk) begin
      if (compare_on && !done) begin
         check_bit("sclk", sclk, m_sclk);
         check_bit("lead_stb (R4)", lead_stb, m_lead);
         check_bit("trail_stb (R4)", trail_stb, m_trail);
         checks++;
         if (lead_stb && trail_stb) begin
            errors++;
            $display("FAIL R8 both strobes: actual 1 expected 0 at %0t", $time);
         end
      end
   end

   task automatic finish_run;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic wait_cycles(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wait_cycles(3);
      // R1: reset values while held
      req_tag = "R1";
      check_bit("sclk in reset", sclk, 1'b0);
      check_bit("lead in reset", lead_stb, 1'b0);
      check_bit("trail in reset", trail_stb, 1'b0);
      rst_n = 1'b1;
      compare_on = 1'b1;
      wait_cycles(2);

      // R3 / R7: linear law, N=2 -> toggle every 3 cycles
      req_tag = "R3";
      law_sel = 1'b1; div_val = 8'd2; cpol = 1'b0; enable = 1'b1;
      wait_cycles(2);
      run = 1'b1;
      wait_cycles(40);

      // R5: stop, clock idles, count reset
      req_tag = "R5";
      run = 1'b0;
      wait_cycles(5);

      // R2: power-of-two law, upper bits ignored: 0x13 -> exponent 3
      req_tag = "R2";
      law_sel = 1'b0; div_val = 8'h13;
      wait_cycles(1);
      run = 1'b1;
      wait_cycles(60);
      run = 1'b0;
      div_val = 8'h00;
      wait_cycles(2);
      run = 1'b1;
      wait_cycles(12);

      // R6: mid-frame changes ignored until frame_done
      req_tag = "R6";
      div_val = 8'h05; cpol = 1'b1; law_sel = 1'b1;
      wait_cycles(20);
      frame_done = 1'b1;
      wait_cycles(1);
      frame_done = 1'b0;
      req_tag = "R7";
      wait_cycles(30);

      // R5: disable with cpol high, clock rests high
      req_tag = "R5";
      enable = 1'b0;
      wait_cycles(6);
      cpol = 1'b0;
      wait_cycles(3);
      cpol = 1'b1;
      wait_cycles(3);

      // R4: cpol high, linear N=0 -> toggle every cycle
      req_tag = "R4";
      law_sel = 1'b1; div_val = 8'd0; enable = 1'b1;
      wait_cycles(20);
      run = 1'b0;
      wait_cycles(3);

      // R2: large exponent 12 -> toggle every 4096 cycles
      req_tag = "R2";
      law_sel = 1'b0; div_val = 8'd12; cpol = 1'b0;
      wait_cycles(1);
      run = 1'b1;
      wait_cycles(9000);

      // R3: largest linear field 255 -> toggle every 256 cycles
      req_tag = "R3";
      run = 1'b0; law_sel = 1'b1; div_val = 8'd255;
      wait_cycles(2);
      run = 1'b1;
      wait_cycles(800);
      run = 1'b0;
      wait_cycles(3);

      finish_run();
   end
endmodule